// File: doc/BRIEF.md
# GPIO Register Bank with Clear/Set/Toggle Aliases

This block is the register bank of a 16-pin general-purpose port. It holds the pin data word, two interrupt mask words and five configuration words: direction, polarity, edge select, both-edge select and input enable. Software reaches the bank over a simple register bus that has single-cycle read and write strobes, a byte offset and an access size. The block drives every stored word straight out to the pin logic next to it.

The data word and both mask words each have three companion addresses. A write to one of them clears, sets or toggles bits of the underlying word, so software never needs a read-modify-write. A read from a companion address returns the underlying word. The input sampling logic can load selected bits of the data word through a separate update port. A bus write aimed at the data word takes priority over that update.

Top module: `gpio_regbank`

## Requirements
- R1: During and after reset, every stored word reads as zero on its output, and both `bus_err` and `bus_rdata` are zero.
- R2: A valid write replaces the whole word at a base offset. The base offsets are 0x00 for data, 0x10 for mask A, 0x20 for mask B, 0x30 for direction, 0x34 for polarity, 0x38 for edge select, 0x3C for both-edge select and 0x40 for input enable. The new value appears on the output in the cycle after the strobe.
- R3: A valid write to base+0x04 of data, mask A or mask B clears each bit of that word that is 1 in `bus_wdata` and leaves the other bits unchanged.
- R4: A valid write to base+0x08 of data, mask A or mask B ORs `bus_wdata` into that word.
- R5: A valid write to base+0x0C of data, mask A or mask B XORs `bus_wdata` into that word.
- R6: A valid read of a base offset or of one of its three companion offsets returns the underlying word on `bus_rdata` in the cycle after `bus_rd`. In any cycle that does not follow a read, `bus_rdata` is zero.
- R7: An access is invalid when `bus_size` is not 2, when offset bits [1:0] are not zero, or when offset/4 is greater than 16. An invalid access raises `bus_err` for exactly the following cycle and changes no word. An invalid read returns zero.
- R8: When `upd_en` is high, each data bit whose `upd_mask` bit is 1 takes the matching bit of `upd_val`. The other data bits keep their values.
- R9: When a valid bus write to any data offset (0x00 to 0x0C) occurs in the same cycle as `upd_en`, the data word takes only the bus result and the update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, registered |
| bus_err | output | 1 | One-cycle invalid-access flag |
| upd_en | input | 1 | Sampled-pin update strobe |
| upd_mask | input | PINS | Data bits to update |
| upd_val | input | PINS | Sampled pin levels |
| pin_data | output | PINS | Data word |
| irq_mask_a | output | PINS | Interrupt mask A |
| irq_mask_b | output | PINS | Interrupt mask B |
| pin_dir | output | PINS | Direction |
| pin_pol | output | PINS | Polarity |
| pin_edge | output | PINS | Edge select |
| pin_both | output | PINS | Both-edge select |
| pin_inen | output | PINS | Input enable |

## Verification
The bench builds the bank with the default values, PINS=16 and ADDR_W=7, so that the 128 possible byte offsets are the whole address space. It sweeps all of them for access sizes 1 to 4, with a write and then a read at each point. This reaches every alias operation, every misaligned, oversized and out-of-range case, and the state left by earlier steps. Update patterns are then driven both alone and against a write to each of the four data offsets.

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
  parameter int PINS   = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  output logic              bus_err,
  input  logic              upd_en,
  input  logic [PINS-1:0]   upd_mask,
  input  logic [PINS-1:0]   upd_val,
  output logic [PINS-1:0]   pin_data,
  output logic [PINS-1:0]   irq_mask_a,
  output logic [PINS-1:0]   irq_mask_b,
  output logic [PINS-1:0]   pin_dir,
  output logic [PINS-1:0]   pin_pol,
  output logic [PINS-1:0]   pin_edge,
  output logic [PINS-1:0]   pin_both,
  output logic [PINS-1:0]   pin_inen
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int N_ALI  = 3;
  localparam int N_CFG  = 5;
  localparam int N_REG  = 4 * N_ALI + N_CFG;

  logic [IDX_W-1:0] idx;
  logic             ok;
  logic             wr_hit;
  logic [1:0]       grp;
  logic [1:0]       op;
  logic [2:0]       csel;
  logic [PINS-1:0]  rd_val;
  logic [PINS-1:0]  ali_q [N_ALI];
  logic [PINS-1:0]  cfg_q [N_CFG];

  assign idx    = bus_addr[ADDR_W-1:2];
  assign ok     = (bus_addr[1:0] == 2'b00) && (bus_size == 3'd2)
                  && (idx < IDX_W'(N_REG));
  assign wr_hit = bus_wr && ok;
  assign grp    = idx[3:2];
  assign op     = idx[1:0];
  assign csel   = idx[2:0] - 3'd4;

  function automatic logic [PINS-1:0] alias_op(input logic [1:0] o,
                                               input logic [PINS-1:0] cur,
                                               input logic [PINS-1:0] w);
    case (o)
      2'd0:    return w;
      2'd1:    return cur & ~w;
      2'd2:    return cur | w;
      default: return cur ^ w;
    endcase
  endfunction

  for (genvar g = 0; g < N_ALI; g++) begin : g_ali
    logic hit;
    assign hit = wr_hit && (idx < IDX_W'(4 * N_ALI)) && (grp == 2'(g));
    if (g == 0) begin : g_data
      always_ff @(posedge clk) begin
        if (!rst_n)
          ali_q[g] <= '0;
        else if (hit)
          ali_q[g] <= alias_op(op, ali_q[g], bus_wdata);
        else if (upd_en)
          ali_q[g] <= (ali_q[g] & ~upd_mask) | (upd_val & upd_mask);
      end
    end else begin : g_mask
      always_ff @(posedge clk) begin
        if (!rst_n)
          ali_q[g] <= '0;
        else if (hit)
          ali_q[g] <= alias_op(op, ali_q[g], bus_wdata);
      end
    end
  end

  for (genvar c = 0; c < N_CFG; c++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[c] <= '0;
      else if (wr_hit && idx == IDX_W'(4 * N_ALI + c))
        cfg_q[c] <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (ok) begin
      if (idx < IDX_W'(4 * N_ALI))
        rd_val = ali_q[grp];
      else
        rd_val = cfg_q[csel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      bus_err   <= (bus_wr || bus_rd) && !ok;
    end
  end

  assign pin_data   = ali_q[0];
  assign irq_mask_a = ali_q[1];
  assign irq_mask_b = ali_q[2];
  assign pin_dir    = cfg_q[0];
  assign pin_pol    = cfg_q[1];
  assign pin_edge   = cfg_q[2];
  assign pin_both   = cfg_q[3];
  assign pin_inen   = cfg_q[4];
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int PINS   = 16,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic              bus_err,
  input logic              upd_en,
  input logic [PINS-1:0]   pin_data,
  input logic [PINS-1:0]   irq_mask_a,
  input logic [PINS-1:0]   irq_mask_b,
  input logic [PINS-1:0]   pin_dir,
  input logic [PINS-1:0]   pin_pol,
  input logic [PINS-1:0]   pin_edge,
  input logic [PINS-1:0]   pin_both,
  input logic [PINS-1:0]   pin_inen
);
  logic bad;
  logic data_wr;
  assign bad = (bus_addr[1:0] != 2'b00) || (bus_size != 3'd2)
               || (bus_addr[ADDR_W-1:2] > (ADDR_W-2)'(16));
  assign data_wr = bus_wr && !bad && (bus_addr[ADDR_W-1:4] == '0);

  AST_RST_IDLE: assert property (@(posedge clk) $past(!rst_n) |-> (pin_data == '0 && bus_err == 1'b0)); // R1
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> $past((bus_wr || bus_rd) && bad)); // R7
  AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && bus_wr && bad) |-> ($stable(irq_mask_a) && $stable(irq_mask_b) && $stable(pin_dir)
                                       && $stable(pin_pol) && $stable(pin_edge) && $stable(pin_both)
                                       && $stable(pin_inen))); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n && !bus_rd) |-> bus_rdata == '0); // R6
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !upd_en && !data_wr) |-> $stable(pin_data)); // R8
  AST_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && upd_en && data_wr && bus_addr[3:2] == 2'd0) |-> pin_data == $past(bus_wdata)); // R9
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && bus_wr && !bad && bus_addr == ADDR_W'(8)) |-> (pin_data & $past(bus_wdata)) == $past(bus_wdata)); // R4
  AST_CLR_MASKA: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && bus_wr && !bad && bus_addr == ADDR_W'(20)) |-> (irq_mask_a & $past(bus_wdata)) == '0); // R3
endmodule

bind gpio_regbank gpio_regbank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .upd_en(upd_en), .pin_data(pin_data), .irq_mask_a(irq_mask_a), .irq_mask_b(irq_mask_b),
  .pin_dir(pin_dir), .pin_pol(pin_pol), .pin_edge(pin_edge), .pin_both(pin_both),
  .pin_inen(pin_inen)
);

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;
  localparam int PINS = 16;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [2:0] bus_size = 3'd2;
  logic [PINS-1:0] bus_wdata = '0, bus_rdata;
  logic bus_err;
  logic upd_en = 1'b0;
  logic [PINS-1:0] upd_mask = '0, upd_val = '0;
  logic [PINS-1:0] pin_data, irq_mask_a, irq_mask_b, pin_dir, pin_pol, pin_edge, pin_both, pin_inen;

  int checks = 0;
  int fails = 0;
  logic [PINS-1:0] m [8];

  always #10 clk = ~clk;

  gpio_regbank #(.PINS(PINS), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .upd_en(upd_en), .upd_mask(upd_mask), .upd_val(upd_val), .pin_data(pin_data),
    .irq_mask_a(irq_mask_a), .irq_mask_b(irq_mask_b), .pin_dir(pin_dir), .pin_pol(pin_pol),
    .pin_edge(pin_edge), .pin_both(pin_both), .pin_inen(pin_inen)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] outs();
    return {pin_data, irq_mask_a, irq_mask_b, pin_dir, pin_pol, pin_edge, pin_both, pin_inen};
  endfunction

  function automatic logic [127:0] model();
    return {m[0], m[1], m[2], m[3], m[4], m[5], m[6], m[7]};
  endfunction

  function automatic bit valid(input int a, input int s);
    return (a % 4 == 0) && (s == 2) && (a / 4 <= 16);
  endfunction

  function automatic string tag(input int a, input int s);
    if (!valid(a, s)) return "R7";
    if (a / 4 >= 12) return "R2";
    case ((a / 4) % 4)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic void mwrite(input int a, input int s, input logic [PINS-1:0] w);
    int i, g;
    if (!valid(a, s)) return;
    i = a / 4;
    if (i >= 12) begin
      m[i - 9] = w;
      return;
    end
    g = i / 4;
    case (i % 4)
      0: m[g] = w;
      1: m[g] = m[g] & ~w;
      2: m[g] = m[g] | w;
      default: m[g] = m[g] ^ w;
    endcase
  endfunction

  function automatic logic [PINS-1:0] mread(input int a, input int s);
    int i;
    if (!valid(a, s)) return '0;
    i = a / 4;
    return (i >= 12) ? m[i - 9] : m[i / 4];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    chk(outs() == '0 && bus_err == 1'b0 && bus_rdata == '0, "R1 in reset", outs(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == '0 && bus_err == 1'b0 && bus_rdata == '0, "R1 after reset", outs(), '0);

    for (int it = 0; it < 2; it++) begin
      for (int a = 0; a < 128; a++) begin
        for (int s = 1; s <= 4; s++) begin
          logic [PINS-1:0] w;
          w = PINS'(a * 16'h9E37) ^ PINS'(s * 16'h5A5A) ^ PINS'(it * 16'h0F0F);
          bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_size = 3'(s); bus_wdata = w;
          @(negedge clk);
          bus_wr = 1'b0;
          mwrite(a, s, w);
          chk(outs() == model(), tag(a, s), outs(), model());
          chk(bus_err == !valid(a, s), valid(a, s) ? "R7 no err" : "R7 err", 128'(bus_err), 128'(!valid(a, s)));
          bus_rd = 1'b1;
          @(negedge clk);
          bus_rd = 1'b0;
          chk(bus_rdata == mread(a, s), valid(a, s) ? "R6 read" : "R7 read zero", 128'(bus_rdata), 128'(mread(a, s)));
          chk(bus_err == !valid(a, s), "R7 read err", 128'(bus_err), 128'(!valid(a, s)));
        end
      end
    end
    @(negedge clk);
    chk(bus_rdata == '0 && bus_err == 1'b0, "R6 idle rdata", 128'(bus_rdata), '0);

    for (int p = 0; p < 16; p++) begin
      logic [PINS-1:0] mk, vl;
      mk = PINS'(p * 16'h1357) ^ 16'hA0C3;
      vl = PINS'(p * 16'h7B29);
      upd_en = 1'b1; upd_mask = mk; upd_val = vl;
      @(negedge clk);
      upd_en = 1'b0;
      m[0] = (m[0] & ~mk) | (vl & mk);
      chk(outs() == model(), "R8 update", outs(), model());
    end

    for (int d = 0; d < 4; d++) begin
      logic [PINS-1:0] w;
      w = PINS'(16'h3C5A + d * 16'h1111);
      upd_en = 1'b1; upd_mask = 16'hFFFF; upd_val = ~m[0];
      bus_wr = 1'b1; bus_addr = ADDR_W'(d * 4); bus_size = 3'd2; bus_wdata = w;
      @(negedge clk);
      bus_wr = 1'b0; upd_en = 1'b0;
      mwrite(d * 4, 2, w);
      chk(outs() == model(), "R9 bus wins", outs(), model());
    end

    upd_en = 1'b1; upd_mask = 16'hFFFF; upd_val = 16'h1234;
    bus_wr = 1'b1; bus_addr = ADDR_W'(2); bus_size = 3'd2; bus_wdata = 16'hFFFF;
    @(negedge clk);
    bus_wr = 1'b0; upd_en = 1'b0;
    m[0] = 16'h1234;
    chk(outs() == model() && bus_err == 1'b1, "R9 R7 invalid write loses", outs(), model());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule